// File: doc/BRIEF.md
# UART Transmit-Empty Interrupt Generator

This block raises the transmit-holding-register-empty interrupt of a 16550-style UART that runs with its transmit FIFO enabled. It watches the FIFO occupancy reported by the transmit path, host writes to the holding register, host reads of the interrupt identification register, the FIFO-enable control bit and the transmit interrupt enable. From these it produces an interrupt request and a 4-bit identification code. It holds no FIFO storage and no serializer.

The empty event is the cycle in which the occupancy falls from nonzero to zero. A small tracker records the highest occupancy, saturated at two, seen since the last time the empty indication was raised. If the FIFO held two or more bytes at once, the indication is raised at once. Otherwise it is held back by one character time less the final stop bit. That time is counted in 16x baud ticks as (frame length in bits − 1) × 16.

A toggle of the FIFO-enable bit while the FIFO is empty raises the indication at once. The interrupt is cleared by a holding-register write or by an identification-register read.

Top module: `uart_thre_irq`

## Requirements
- R1: `irq` is 1 only while `fifo_en` and `thr_ie` are both 1. The pending state is held while either is 0, so `irq` returns as soon as both are 1 again.
- R2: `iir_code` is 4'h2 while `irq` is 1 and 4'h1 otherwise.
- R3: A cycle with `thr_wr`=1 leaves the interrupt cleared on the next cycle. This holds even if an empty event, timer expiry or enable toggle falls in that same cycle, and the write also cancels a running delay.
- R4: A cycle with `iir_rd`=1 clears the pending interrupt. If a set event falls in that same cycle, the set wins and `irq` is 1 on the next cycle.
- R5: When an empty event occurs and the occupancy reached 2 or more since the last set, `irq` is 1 on the following cycle.
- R6: When an empty event occurs and the peak occupancy stayed below 2, the interrupt is set at the clock edge that carries the D-th `baud16_tick` after the empty-event cycle. D = (`frame_bits` − 1) × 16, a `frame_bits` value below 2 counts as 2, and ticks in the empty-event cycle itself are not counted.
- R7: If the occupancy becomes nonzero before the delay expires, the delay is abandoned. A later empty event starts a full new delay.
- R8: When `fifo_en` differs from its value in the previous cycle (0 at reset) and the occupancy is 0, the interrupt is set on the next cycle and any running delay is cancelled.
- R9: The peak tracker is cleared whenever the interrupt is set. An occupancy of up to 16 loaded while the interrupt is serviced is counted toward the next peak.
- R10: After reset `irq` is 0 and `iir_code` is 4'h1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | FIFO-enable control bit |
| thr_ie | input | 1 | Transmit-empty interrupt enable |
| tx_level | input | LVL_W | Transmit FIFO occupancy |
| thr_wr | input | 1 | Holding-register write strobe |
| iir_rd | input | 1 | Identification-register read strobe |
| baud16_tick | input | 1 | One-cycle pulse at 16x the baud rate |
| frame_bits | input | FRAME_W | Character frame length in bits, stop bits included |
| irq | output | 1 | Interrupt request |
| iir_code | output | 4 | Identification code (2 = holding register empty, 1 = none) |

## Verification
The two collisions that matter are a set event and a clear in the same cycle. The bench provokes an immediate empty event in the same cycle as an identification-register read, where the set must survive. It also drives an empty event in the same cycle as a holding-register write, where the write must win. A reference model written with plain integers updates on every edge and is compared with `irq` and `iir_code` on every cycle. Explicit checks then sample the cycle after each collision.

// File: rtl/uart_thre_pkg.sv
package uart_thre_pkg;
  localparam logic [3:0] IIR_THRE = 4'h2;
  localparam logic [3:0] IIR_NONE = 4'h1;

  // Ticks of the 16x clock for one character less the last stop bit.
  function automatic int unsigned char_ticks(input int unsigned bits);
    int unsigned b;
    b = (bits < 2) ? 2 : bits;
    return (b - 1) * 16;
  endfunction
endpackage

// File: rtl/thre_peak_track.sv
module thre_peak_track #(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic             clr,
  output logic             empty_evt,
  output logic             peak_hi
);
  logic [1:0] peak_q;
  logic       nonempty_q;

  assign empty_evt = nonempty_q && (level == '0);
  assign peak_hi   = (peak_q == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      peak_q     <= 2'd0;
      nonempty_q <= 1'b0;
    end else begin
      nonempty_q <= (level != '0);
      if (clr)
        peak_q <= 2'd0;
      else if (level >= LVL_W'(2))
        peak_q <= 2'd2;
      else if (level == LVL_W'(1) && peak_q == 2'd0)
        peak_q <= 2'd1;
    end
  end
endmodule

// File: rtl/thre_char_timer.sv
module thre_char_timer #(
  parameter int FRAME_W = 4,
  parameter int CNT_W   = FRAME_W + 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               abort,
  input  logic               tick,
  input  logic [FRAME_W-1:0] frame_bits,
  output logic               busy,
  output logic               done
);
  import uart_thre_pkg::*;

  logic [CNT_W-1:0] cnt_q;

  assign busy = (cnt_q != '0);
  assign done = busy && tick && (cnt_q == CNT_W'(1)) && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (abort)
      cnt_q <= '0;
    else if (start)
      cnt_q <= CNT_W'(char_ticks(int'(frame_bits)));
    else if (busy && tick)
      cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/thre_pend_latch.sv
module thre_pend_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic wr_clr,
  input  logic rd_clr,
  output logic pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pend <= 1'b0;
    else if (wr_clr)
      pend <= 1'b0;
    else if (set_evt)
      pend <= 1'b1;
    else if (rd_clr)
      pend <= 1'b0;
  end
endmodule

// File: rtl/uart_thre_irq.sv
module uart_thre_irq #(
  parameter int LVL_W   = 5,
  parameter int FRAME_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fifo_en,
  input  logic               thr_ie,
  input  logic [LVL_W-1:0]   tx_level,
  input  logic               thr_wr,
  input  logic               iir_rd,
  input  logic               baud16_tick,
  input  logic [FRAME_W-1:0] frame_bits,
  output logic               irq,
  output logic [3:0]         iir_code
);
  import uart_thre_pkg::*;
  localparam int CNT_W = FRAME_W + 4;

  logic fifo_en_q;
  logic lvl_zero, en_set, empty_evt, peak_hi;
  logic imm_set, dly_start, dly_abort, dly_busy, dly_done;
  logic set_evt, peak_clr, pend;

  assign lvl_zero  = (tx_level == '0);
  assign en_set    = (fifo_en != fifo_en_q) && lvl_zero;
  assign imm_set   = empty_evt && peak_hi;
  assign dly_abort = thr_wr || !lvl_zero || en_set;
  assign dly_start = empty_evt && !peak_hi;
  assign set_evt   = imm_set || dly_done || en_set;
  assign peak_clr  = set_evt && !thr_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fifo_en_q <= 1'b0;
    else        fifo_en_q <= fifo_en;
  end

  thre_peak_track #(.LVL_W(LVL_W)) u_peak (
    .clk(clk), .rst_n(rst_n), .level(tx_level), .clr(peak_clr),
    .empty_evt(empty_evt), .peak_hi(peak_hi)
  );

  thre_char_timer #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(dly_start), .abort(dly_abort),
    .tick(baud16_tick), .frame_bits(frame_bits),
    .busy(dly_busy), .done(dly_done)
  );

  thre_pend_latch u_pend (
    .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .wr_clr(thr_wr),
    .rd_clr(iir_rd), .pend(pend)
  );

  assign irq      = pend && fifo_en && thr_ie;
  assign iir_code = irq ? IIR_THRE : IIR_NONE;
endmodule

// File: rtl/uart_thre_irq_chk.sv
module uart_thre_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fifo_en,
  input logic       thr_ie,
  input logic       thr_wr,
  input logic       iir_rd,
  input logic       irq,
  input logic [3:0] iir_code,
  input logic       pend,
  input logic       set_evt,
  input logic       empty_evt,
  input logic       peak_hi,
  input logic       en_set
);
  p_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (fifo_en && thr_ie && iir_code == 4'h2));

  p_wr_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !pend);

  p_set_beats_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && set_evt && !thr_wr) |=> pend);

  p_rd_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && !set_evt && !thr_wr) |=> !pend);

  p_imm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_evt && peak_hi && !thr_wr) |=> pend);

  p_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_evt && !peak_hi && !en_set && !pend && !set_evt) |=> !pend);

  p_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_set && !thr_wr) |=> pend);

  p_rise_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(set_evt));
endmodule

bind uart_thre_irq uart_thre_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .thr_ie(thr_ie),
  .thr_wr(thr_wr), .iir_rd(iir_rd), .irq(irq), .iir_code(iir_code),
  .pend(pend), .set_evt(set_evt), .empty_evt(empty_evt),
  .peak_hi(peak_hi), .en_set(en_set)
);

// File: tb/tb_uart_thre_irq.sv
module tb_uart_thre_irq;
  localparam int LVL_W = 5;
  localparam int FRAME_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 1'b0, thr_ie = 1'b0, thr_wr = 1'b0, iir_rd = 1'b0, tick = 1'b0;
  logic [LVL_W-1:0] level = '0;
  logic [FRAME_W-1:0] fbits = 4'd4;
  logic irq;
  logic [3:0] iir_code;

  int n_chk = 0, n_bad = 0, cyc_n = 0;
  string cur = "R10";

  // reference model state
  int m_pend = 0, m_ne = 0, m_peak = 0, m_cnt = 0, m_enq = 0;

  always #2.5 clk = ~clk;

  uart_thre_irq #(.LVL_W(LVL_W), .FRAME_W(FRAME_W)) dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .thr_ie(thr_ie),
    .tx_level(level), .thr_wr(thr_wr), .iir_rd(iir_rd),
    .baud16_tick(tick), .frame_bits(fbits), .irq(irq), .iir_code(iir_code)
  );

  always @(negedge clk) begin
    cyc_n++;
    tick = (cyc_n % 2 == 0);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0; m_ne = 0; m_peak = 0; m_cnt = 0; m_enq = 0;
    end else begin
      int lv, fb, empty, ensel, set, nxt;
      lv = int'(level);
      fb = (int'(fbits) < 2) ? 2 : int'(fbits);
      empty = (m_ne != 0 && lv == 0);
      ensel = (int'(fifo_en) != m_enq) && lv == 0;
      set = (empty && m_peak >= 2) || ensel ||
            (m_cnt == 1 && tick && lv == 0 && !thr_wr);
      if (thr_wr || lv != 0 || ensel) nxt = 0;
      else if (empty && m_peak < 2) nxt = (fb - 1) * 16;
      else if (m_cnt > 0 && tick) nxt = m_cnt - 1;
      else nxt = m_cnt;
      m_cnt = nxt;
      if (set && !thr_wr) m_peak = 0;
      else if (lv > m_peak) m_peak = (lv >= 2) ? 2 : lv;
      if (thr_wr) m_pend = 0;
      else if (set) m_pend = 1;
      else if (iir_rd) m_pend = 0;
      m_ne = (lv != 0);
      m_enq = int'(fifo_en);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc_n);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      int e_irq;
      @(posedge clk);
      @(negedge clk);
      e_irq = (m_pend != 0 && fifo_en && thr_ie) ? 1 : 0;
      check({cur, " irq"}, int'(irq), e_irq);
      check({cur, " iir_code"}, int'(iir_code), e_irq ? 2 : 1);
    end
  endtask

  task automatic pulse_wr();
    thr_wr = 1'b1; cyc(1); thr_wr = 1'b0;
  endtask

  task automatic pulse_rd();
    iir_rd = 1'b1; cyc(1); iir_rd = 1'b0;
  endtask

  initial begin
    #1;
    repeat (3) @(negedge clk);
    check("R10 irq", int'(irq), 0);
    check("R10 iir_code", int'(iir_code), 1);
    rst_n = 1'b1;
    cyc(2);

    cur = "R8"; fifo_en = 1'b1; thr_ie = 1'b1; cyc(1);
    check("R8 toggle sets", int'(irq), 1);

    cur = "R4"; pulse_rd();
    check("R4 read clears", int'(irq), 0);

    cur = "R9"; level = 5'd1; pulse_wr();
    for (int k = 2; k <= 16; k++) begin level = LVL_W'(k); cyc(1); end
    check("R3 write clears", int'(irq), 0);
    for (int k = 15; k >= 0; k--) begin level = LVL_W'(k); cyc(1); end
    cur = "R5";
    check("R5 immediate", int'(irq), 1);
    check("R2 code", int'(iir_code), 2);

    cur = "R6"; pulse_wr(); level = 5'd1; cyc(1); level = 5'd0; cyc(5);
    check("R6 held", int'(irq), 0);
    cyc(100);
    check("R6 expired", int'(irq), 1);

    cur = "R7"; pulse_rd(); level = 5'd1; cyc(1); level = 5'd0; cyc(40);
    level = 5'd1; cyc(2); level = 5'd0; cyc(60);
    check("R7 restarted", int'(irq), 0);
    cyc(50);
    check("R7 second expiry", int'(irq), 1);

    cur = "R4"; pulse_rd(); level = 5'd2; cyc(1);
    level = 5'd0; iir_rd = 1'b1; cyc(1); iir_rd = 1'b0;
    check("R4 set beats read", int'(irq), 1);

    cur = "R3"; pulse_rd(); level = 5'd2; cyc(1);
    level = 5'd0; pulse_wr();
    check("R3 write beats set", int'(irq), 0);
    cyc(120);
    check("R3 nothing later", int'(irq), 0);

    cur = "R1"; thr_ie = 1'b0; level = 5'd3; cyc(1); level = 5'd0; cyc(2);
    check("R1 masked", int'(irq), 0);
    thr_ie = 1'b1; cyc(1);
    check("R1 unmasked", int'(irq), 1);

    cur = "R9"; pulse_rd(); level = 5'd1; cyc(1); level = 5'd0; cyc(3);
    check("R9 peak cleared", int'(irq), 0);
    cyc(100);

    cur = "R8"; pulse_rd(); fifo_en = 1'b0; cyc(2);
    check("R1 fifo off", int'(irq), 0);
    fifo_en = 1'b1; cyc(1);
    check("R8 toggle back", int'(irq), 1);

    cur = "R6"; pulse_rd(); fbits = 4'd1; level = 5'd1; cyc(1); level = 5'd0; cyc(30);
    check("R6 short frame held", int'(irq), 0);
    cyc(6);
    check("R6 short frame expired", int'(irq), 1);
    cyc(4);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule